// File: doc/BRIEF.md
# Float Result Clamp Stage

This stage sits just before a register-file writeback and limits a single-precision floating-point result to a chosen range. A 2-bit mode selects the range. Each bit drives its own clamp: one sets a floor at zero, the other holds the magnitude within one. Setting both bits limits the value to the unit interval, and the result is the same whichever clamp is applied first.

The clamps work directly on the sign, exponent and mantissa fields. No general float comparator is used. NaN and signed zero have fixed outcomes, so the result is always a defined number whenever a clamp is active. The result is registered and appears one clock after the operand and mode are presented. The parameter `ZERO_FIRST` picks the order of the two clamps inside the datapath. It has no effect on the result.

Top module: `fclamp_stage`

## Requirements
- R1: With mode 2'b00 the output equals the input bit for bit, NaN payloads included.
- R2: With mode 2'b01 (bit 0 = zero floor) any input with sign bit 1 (negative values, -inf) gives +0.0 (0x00000000), and any non-NaN input with sign bit 0, including +inf, passes unchanged.
- R3: With mode 2'b10 (bit 1 = symmetric unit clamp) a non-NaN input whose magnitude exceeds 1.0, infinities included, gives +1.0 (0x3F800000) or -1.0 (0xBF800000) according to its sign, and any other non-NaN input passes unchanged.
- R4: With mode 2'b11 the output lies in [0, 1] and equals the zero floor applied after the unit clamp, which in turn equals the unit clamp applied after the zero floor.
- R5: A NaN input (exponent all ones, mantissa nonzero) gives +0.0 whenever mode bit 0 is set, and -1.0 (0xBF800000) under mode 2'b10.
- R6: -0.0 (0x80000000) gives +0.0 whenever mode bit 0 is set and stays -0.0 under mode 2'b10.
- R7: The output is registered. It reflects the operand and mode sampled at the previous rising clock edge, and it reads 0x00000000 while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| val_i | input | 32 | Single-precision operand |
| mode_i | input | 2 | Clamp select: bit 0 zero floor, bit 1 unit clamp |
| res_o | output | 32 | Clamped result, one cycle later |

## Verification
The zero floor and the unit clamp can act in the same cycle under mode 2'b11. This is provoked with operands that trip both clamps at once: values below -1, -inf, NaN and -0.0. Random operands biased toward exponents near the bias are also applied with mode 2'b11. The bench models each clamp as a separate function, applies them in both orders, requires the two orders to agree, and compares the registered output with that value one cycle later.

// File: rtl/fclamp_pkg.sv
package fclamp_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] EXP_MAX  = {EXP_W{1'b1}};

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_t;

  localparam fp_t FP_PZERO = '{sgn: 1'b0, exp: '0, man: '0};
  localparam fp_t FP_PONE  = '{sgn: 1'b0, exp: EXP_BIAS, man: '0};
  localparam fp_t FP_MONE  = '{sgn: 1'b1, exp: EXP_BIAS, man: '0};

  function automatic logic is_nan(fp_t a);
    return (a.exp == EXP_MAX) && (a.man != '0);
  endfunction

  // |a| > 1.0 for non-NaN a: magnitude fields compare as an unsigned integer
  function automatic logic above_one(fp_t a);
    return {a.exp, a.man} > {EXP_BIAS, {MAN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/fclamp_zero_floor.sv
module fclamp_zero_floor
  import fclamp_pkg::*;
(
  input  fp_t  a_i,
  input  logic en_i,
  output fp_t  y_o
);
  logic floor_hit;

  // NaN and anything with the sign bit set (incl. -0.0) floor to +0.0
  assign floor_hit = a_i.sgn || is_nan(a_i);

  always_comb begin
    y_o = a_i;
    if (en_i && floor_hit) y_o = FP_PZERO;
  end
endmodule

// File: rtl/fclamp_unit_sym.sv
module fclamp_unit_sym
  import fclamp_pkg::*;
(
  input  fp_t  a_i,
  input  logic en_i,
  output fp_t  y_o
);
  logic nan_in, over;

  assign nan_in = is_nan(a_i);
  assign over   = !nan_in && above_one(a_i);

  always_comb begin
    y_o = a_i;
    if (en_i) begin
      if (nan_in)    y_o = FP_MONE;
      else if (over) y_o = a_i.sgn ? FP_MONE : FP_PONE;
    end
  end
endmodule

// File: rtl/fclamp_stage.sv
module fclamp_stage
  import fclamp_pkg::*;
#(
  parameter bit ZERO_FIRST = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FP_W-1:0] val_i,
  input  logic [1:0]      mode_i,
  output logic [FP_W-1:0] res_o
);
  localparam int M_FLOOR = 0;
  localparam int M_UNIT  = 1;

  fp_t op, mid, fin;
  logic en_floor, en_unit;

  assign op       = fp_t'(val_i);
  assign en_floor = mode_i[M_FLOOR];
  assign en_unit  = mode_i[M_UNIT];

  generate
    if (ZERO_FIRST) begin : g_floor_first
      fclamp_zero_floor u_floor (.a_i(op),  .en_i(en_floor), .y_o(mid));
      fclamp_unit_sym   u_unit  (.a_i(mid), .en_i(en_unit),  .y_o(fin));
    end else begin : g_unit_first
      fclamp_unit_sym   u_unit  (.a_i(op),  .en_i(en_unit),  .y_o(mid));
      fclamp_zero_floor u_floor (.a_i(mid), .en_i(en_floor), .y_o(fin));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= fin;
  end

  p_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (res_o == $past(val_i)));

  p_floor_nonneg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[M_FLOOR] |=> !res_o[FP_W-1]);

  p_unit_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[M_UNIT] |=> (res_o[FP_W-2:0] <= {EXP_BIAS, {MAN_W{1'b0}}}));

  p_unit_interval_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> (!res_o[FP_W-1] && res_o[FP_W-2:0] <= {EXP_BIAS, {MAN_W{1'b0}}}));

  p_nan_unit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && is_nan(op)) |=> (res_o == FP_MONE));

  p_negzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[M_FLOOR] && val_i == {1'b1, {(FP_W-1){1'b0}}}) |=> (res_o == '0));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) p_reset_zero_r7: assert (res_o == '0);
  end
endmodule

// File: tb/fclamp_stage_tb.sv
module fclamp_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] val = '0;
  logic [1:0]  mode = '0;
  logic [31:0] res;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fclamp_stage u_dut (.clk_i(clk), .rst_ni(rst_n), .val_i(val), .mode_i(mode), .res_o(res));

  function automatic bit nan_f(logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic [31:0] floor_f(logic [31:0] x);
    if (nan_f(x) || x[31]) return 32'h0000_0000;
    return x;
  endfunction

  function automatic logic [31:0] unit_f(logic [31:0] x);
    if (nan_f(x)) return 32'hBF80_0000;
    if (x[30:0] > 31'h3F80_0000) return x[31] ? 32'hBF80_0000 : 32'h3F80_0000;
    return x;
  endfunction

  function automatic logic [31:0] ref_f(logic [31:0] x, logic [1:0] m);
    logic [31:0] a, b;
    case (m)
      2'b00: return x;
      2'b01: return floor_f(x);
      2'b10: return unit_f(x);
      default: begin
        a = floor_f(unit_f(x));
        b = unit_f(floor_f(x));
        if (a !== b) $display("FAIL R4 model orders disagree act=%h exp=%h", a, b);
        return a;
      end
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic apply(string tag, logic [31:0] v, logic [1:0] m);
    @(negedge clk);
    val = v; mode = m;
    @(negedge clk);
    chk(tag, res, ref_f(v, m));
  endtask

  function automatic logic [31:0] rnd_val();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 4)
      0: r[30:23] = 8'd124 + 8'($urandom % 6);
      1: r[30:23] = ($urandom % 2) ? 8'hFF : 8'h00;
      2: r[22:0]  = ($urandom % 2) ? 23'd0 : r[22:0];
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    val = 32'hC0A0_0000; mode = 2'b00;
    repeat (3) @(negedge clk);
    chk("R7 reset value", res, 32'h0);
    rst_n = 1'b1;

    // R7 latency: output holds previous value until the edge
    @(negedge clk); val = 32'h4000_0000; mode = 2'b10;
    @(posedge clk); #1;
    @(negedge clk); val = 32'h3E80_0000; mode = 2'b00;
    chk("R7 one-cycle latency", res, 32'h3F80_0000);
    @(negedge clk);
    chk("R7 next sample", res, 32'h3E80_0000);

    apply("R1 pass nan", 32'h7FC0_1234, 2'b00);
    apply("R1 pass negative", 32'hC2C8_0000, 2'b00);
    apply("R2 negative floors", 32'hBF00_0000, 2'b01);
    apply("R2 -inf floors", 32'hFF80_0000, 2'b01);
    apply("R2 +inf passes", 32'h7F80_0000, 2'b01);
    apply("R2 positive passes", 32'h4479_8000, 2'b01);
    apply("R3 big positive", 32'h4120_0000, 2'b10);
    apply("R3 big negative", 32'hC120_0000, 2'b10);
    apply("R3 +inf", 32'h7F80_0000, 2'b10);
    apply("R3 just above one", 32'h3F80_0001, 2'b10);
    apply("R3 exactly -1", 32'hBF80_0000, 2'b10);
    apply("R3 small negative passes", 32'hBE00_0000, 2'b10);
    apply("R4 below -1", 32'hC0A0_0000, 2'b11);
    apply("R4 above 1", 32'h42F6_0000, 2'b11);
    apply("R4 -inf", 32'hFF80_0000, 2'b11);
    apply("R4 inside", 32'h3F40_0000, 2'b11);
    apply("R5 nan floor", 32'hFFC0_0000, 2'b01);
    apply("R5 nan unit", 32'h7FC0_0000, 2'b10);
    apply("R5 nan both", 32'h7F80_0001, 2'b11);
    apply("R6 negzero floor", 32'h8000_0000, 2'b01);
    apply("R6 negzero both", 32'h8000_0000, 2'b11);
    apply("R6 negzero unit", 32'h8000_0000, 2'b10);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      m = 2'($urandom);
      case (m)
        2'b00: apply("R1 random", rnd_val(), m);
        2'b01: apply("R2 random", rnd_val(), m);
        2'b10: apply("R3 random", rnd_val(), m);
        default: apply("R4 random", rnd_val(), m);
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule